// File: doc/BRIEF.md
# Control-Stream Loaded Timeslot Switch

This block is a timeslot interchange for two input and two output TDM streams. Each stream carries 32 eight-bit channels per frame. A stream port upstream does the bit-level shifting. For each timeslot it hands over one byte per data input and one byte per control input, together with a channel counter and a strobe.

The switch stores each received frame in a double-buffered data memory. For every output channel it consults a connect memory entry. That entry gives an output enable, a source stream and a source channel. The selected byte comes from the last complete frame.

In serial-bus mode, two frame-aligned control streams load the connect memory. The byte in control channel n of control stream s becomes the entry for output channel n of output stream s. A small framing state machine decides when a timeslot is trusted.

- **Framing states:**
  - `ST_IDLE` waits for channel 0.
  - `ST_FILL` collects the first full frame with all outputs off.
  - `ST_RUN` switches traffic.
- **Framing transitions:**
  - IDLE to FILL on a strobe carrying channel 0.
  - FILL to RUN on the last channel.
  - FILL or RUN back to IDLE (slip) on a strobe whose channel number is not the expected one.
  - RUN stays in RUN across frame boundaries.

Top module: `tsi_ctl_switch`

## Requirements
- R1: After reset every connect memory entry has its enable bit (bit 7) at 0. `out_valid`, `oe0` and `oe1` are low, and outputs stay disabled until an entry with bit 7 set is loaded.
- R2: Each output channel's enable is bit 7 of its connect memory entry. A disabled channel drives `oe` low and its data port reads 0x00.
- R3: Entry bit 5 selects the source input stream (0 or 1). Entry bits 4:0 select the source channel. Bit 6 has no effect.
- R4: In a trusted timeslot with `bus_mode` high, `ctl0` writes the entry of output stream 0 and `ctl1` writes the entry of output stream 1, each at the timeslot's channel number. Bytes in untrusted timeslots are never written.
- R5: With `bus_mode` low, the control bytes have no effect on the connect memory.
- R6: Output data always comes from the last fully received frame. It is never taken from the frame being received, even when the source channel has already arrived in the current frame.
- R7: The output for channel n uses the entry as it stood before that timeslot's own control write. A write to entry n therefore acts from the next frame on.
- R8: One clock after a trusted timeslot, `out_valid` is high and `out_ch` equals that timeslot's channel number. After an untrusted timeslot or an idle cycle, `out_valid` is low.
- R9: The framing machine trusts a timeslot as follows:
  - In IDLE, only a channel 0 is trusted; it moves the machine to FILL.
  - In FILL and RUN, a timeslot is trusted when its channel number is the expected one; a channel-number slip returns the machine to IDLE without trusting the slot.
  - In FILL, outputs stay disabled, and the last channel moves the machine to RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Strobe: one timeslot of bytes is present |
| ch_idx | input | 5 | Channel number of the present timeslot |
| bus_mode | input | 1 | Serial-bus mode: control streams load the connect memory |
| din0 | input | 8 | Byte from data input stream 0 |
| din1 | input | 8 | Byte from data input stream 1 |
| ctl0 | input | 8 | Byte from control stream 0 (entries of output 0) |
| ctl1 | input | 8 | Byte from control stream 1 (entries of output 1) |
| out_valid | output | 1 | An output timeslot is presented |
| out_ch | output | 5 | Channel number of the presented output timeslot |
| dout0 | output | 8 | Byte for output stream 0 |
| dout1 | output | 8 | Byte for output stream 1 |
| oe0 | output | 1 | Drive enable for the output 0 channel |
| oe1 | output | 1 | Drive enable for the output 1 channel |

## Verification
The bench maps each output channel to the opposite stream in reversed channel order. With that mapping, outputs in the upper half of a frame read source channels that have already been overwritten in the current frame. A single-buffered memory would show the new frame's bytes there.

The bench loads a second mapping during the frame that still uses the first. A design that applied control writes at once would switch maps one frame early.

The bench feeds junk control bytes with `bus_mode` low, and an all-ones byte in a slipped timeslot. A design that wrote either would corrupt later frames.

The bench also drives a slip mid-frame, followed by a full refill. A design without proper resynchronisation would emit traffic from a torn frame or skip the disabled fill frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NSTR    = 2;
    localparam int EN_BIT  = 7;
    localparam int SEL_BIT = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } tsi_state_e;
endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
    import tsi_pkg::*;
#(
    parameter int NCH = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_valid,
    input  logic [CW-1:0] ch_idx,
    output logic          slot_acc,
    output logic          run_slot,
    output logic          rd_bank
);
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    tsi_state_e    state_q, state_d;
    logic [CW-1:0] exp_q;
    logic          bank_q;
    logic          is_last;

    assign is_last = (ch_idx == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            exp_q   <= '0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (slot_acc) begin
                exp_q <= is_last ? '0 : ch_idx + 1'b1;
                if (is_last) bank_q <= ~bank_q;
            end
        end
    end

    always_comb begin
        state_d  = state_q;
        slot_acc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ch_valid && ch_idx == '0) begin
                    slot_acc = 1'b1;
                    state_d  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (ch_valid) begin
                    if (ch_idx == exp_q) begin
                        slot_acc = 1'b1;
                        if (is_last) state_d = ST_RUN;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_RUN: begin
                if (ch_valid && ch_idx != exp_q) state_d = ST_IDLE;
                else if (ch_valid) slot_acc = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign run_slot = slot_acc && (state_q == ST_RUN);
    assign rd_bank  = bank_q;

    // R9
    idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ch_valid && ch_idx != '0) |=> (state_q == ST_IDLE));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_acc && is_last) |=> $stable(bank_q));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [CW-1:0]            wr_ch,
    input  logic [NSTR-1:0][DW-1:0]  wr_data,
    input  logic                     rd_bank,
    input  logic [NSTR-1:0]          rd_str,
    input  logic [NSTR-1:0][CW-1:0]  rd_ch,
    output logic [NSTR-1:0][DW-1:0]  rd_data
);
    logic [DW-1:0] mem [2][NSTR][NCH];

    for (genvar s = 0; s < NSTR; s++) begin : g_str
        always_ff @(posedge clk) begin
            if (wr_en) mem[wr_bank][s][wr_ch] <= wr_data[s];
        end
        assign rd_data[s] = mem[rd_bank][rd_str[s]][rd_ch[s]];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int NCH = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CW-1:0]          ch,
    input  logic [NSTR-1:0][7:0]   wr_entry,
    output logic [NSTR-1:0][7:0]   rd_entry
);
    logic [7:0] cm [NSTR][NCH];

    for (genvar s = 0; s < NSTR; s++) begin : g_str
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NCH; i++) cm[s][i] <= '0;
            end else if (wr_en) begin
                cm[s][ch] <= wr_entry[s];
            end
        end
        assign rd_entry[s] = cm[s][ch];

        // R5
        cm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(cm[s][0]));
    end
endmodule

// File: rtl/tsi_ctl_switch.sv
module tsi_ctl_switch
    import tsi_pkg::*;
#(
    parameter int NCH = 32,
    parameter int DW  = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_valid,
    input  logic [CW-1:0] ch_idx,
    input  logic          bus_mode,
    input  logic [DW-1:0] din0,
    input  logic [DW-1:0] din1,
    input  logic [7:0]    ctl0,
    input  logic [7:0]    ctl1,
    output logic          out_valid,
    output logic [CW-1:0] out_ch,
    output logic [DW-1:0] dout0,
    output logic [DW-1:0] dout1,
    output logic          oe0,
    output logic          oe1
);
    logic                    slot_acc, run_slot, rd_bank;
    logic [NSTR-1:0][7:0]    ent, ctl_in;
    logic [NSTR-1:0][DW-1:0] din_in, rd_data;
    logic [NSTR-1:0]         src_str;
    logic [NSTR-1:0][CW-1:0] src_ch;
    logic [NSTR-1:0][DW-1:0] dout_q;
    logic [NSTR-1:0]         oe_q;

    assign din_in = {din1, din0};
    assign ctl_in = {ctl1, ctl0};

    tsi_frame_ctl #(.NCH(NCH)) u_ctl (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_idx(ch_idx),
        .slot_acc(slot_acc), .run_slot(run_slot), .rd_bank(rd_bank)
    );

    tsi_conn_mem #(.NCH(NCH)) u_cm (
        .clk(clk), .rst_n(rst_n), .wr_en(slot_acc && bus_mode),
        .ch(ch_idx), .wr_entry(ctl_in), .rd_entry(ent)
    );

    for (genvar s = 0; s < NSTR; s++) begin : g_sel
        assign src_str[s] = ent[s][SEL_BIT];
        assign src_ch[s]  = ent[s][CW-1:0];
    end

    tsi_data_mem #(.NCH(NCH), .DW(DW)) u_dm (
        .clk(clk), .wr_en(slot_acc), .wr_bank(~rd_bank), .wr_ch(ch_idx),
        .wr_data(din_in), .rd_bank(rd_bank), .rd_str(src_str),
        .rd_ch(src_ch), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            oe_q      <= '0;
            dout_q    <= '0;
        end else begin
            out_valid <= slot_acc;
            if (slot_acc) out_ch <= ch_idx;
            for (int s = 0; s < NSTR; s++) begin
                oe_q[s]   <= run_slot && ent[s][EN_BIT];
                dout_q[s] <= (run_slot && ent[s][EN_BIT]) ? rd_data[s] : '0;
            end
        end
    end

    assign oe0   = oe_q[0];
    assign oe1   = oe_q[1];
    assign dout0 = dout_q[0];
    assign dout1 = dout_q[1];

    // R8
    out_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_acc |=> (out_valid && out_ch == $past(ch_idx)));

    // R9
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_slot |=> (!oe0 && !oe1));

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe0 |-> (dout0 == '0));
endmodule

// File: tb/tsi_ctl_switch_test.sv
module tsi_ctl_switch_test;
    localparam int CLK_P = 10;
    localparam int NCH   = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ch_valid = 1'b0, bus_mode = 1'b0;
    logic [4:0] ch_idx = '0;
    logic [7:0] din0 = '0, din1 = '0, ctl0 = '0, ctl1 = '0;
    logic out_valid, oe0, oe1;
    logic [4:0] out_ch;
    logic [7:0] dout0, dout1;

    int checks = 0, errors = 0, fr = 0;
    bit done = 0;
    logic [7:0] prev [2][NCH];
    logic [7:0] cur  [2][NCH];
    logic [7:0] cm   [2][NCH];

    always #(CLK_P/2) clk = ~clk;

    tsi_ctl_switch uut (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_idx(ch_idx),
        .bus_mode(bus_mode), .din0(din0), .din1(din1), .ctl0(ctl0), .ctl1(ctl1),
        .out_valid(out_valid), .out_ch(out_ch), .dout0(dout0), .dout1(dout1),
        .oe0(oe0), .oe1(oe1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (frame %0d)", req, act, exp, fr);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int f, input int n);
        return 8'((f * 37 + n * 5 + s * 101) & 255);
    endfunction

    function automatic logic [7:0] ctl_byte(input int kind, input int s, input int n);
        case (kind)
            0:       return {1'b1, 1'b1, ~1'(s), 5'(31 - n)};
            1:       return {(n % 3) != 0, 1'b0, 1'(s), 5'((n * 7 + 3) % 32)};
            default: return 8'hA5 ^ 8'(n);
        endcase
    endfunction

    // One timeslot: drive, predict, check after the capturing edge.
    task automatic slot(input int idx, input bit bm, input int kind, input bit run, input bit acc);
        logic [7:0] e [2];
        logic [7:0] ed [2];
        logic       eo [2];
        logic [7:0] c [2];
        for (int s = 0; s < 2; s++) begin
            c[s]  = (kind < 0) ? 8'hFF : ctl_byte(kind, s, idx);
            e[s]  = acc ? cm[s][idx] : 8'h00;
            eo[s] = acc && run && e[s][7];
            ed[s] = eo[s] ? prev[e[s][5]][e[s][4:0]] : 8'h00;
        end
        ch_valid = 1'b1; ch_idx = 5'(idx); bus_mode = bm;
        din0 = pat(0, fr, idx); din1 = pat(1, fr, idx);
        ctl0 = c[0]; ctl1 = c[1];
        if (acc) begin
            cur[0][idx] = din0; cur[1][idx] = din1;
            if (bm) begin cm[0][idx] = c[0]; cm[1][idx] = c[1]; end
        end
        @(negedge clk);
        check(out_valid == acc, "R8 out_valid", out_valid, acc);
        if (acc) check(out_ch == 5'(idx), "R8 out_ch", out_ch, idx);
        check(oe0 == eo[0] && dout0 == ed[0], run ? "R2/R3/R6/R7 out0" : "R9 out0",
              {oe0, dout0}, {eo[0], ed[0]});
        check(oe1 == eo[1] && dout1 == ed[1], run ? "R2/R3/R6/R7 out1" : "R9 out1",
              {oe1, dout1}, {eo[1], ed[1]});
    endtask

    task automatic frame(input bit bm, input int kind, input bit run);
        for (int n = 0; n < NCH; n++) slot(n, bm, kind, run, 1'b1);
        prev = cur;
        fr++;
    endtask

    task automatic idle_cycle();
        ch_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && !oe0 && !oe1, "R8 idle", {out_valid, oe0, oe1}, 0);
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < NCH; n++) begin cm[s][n] = 8'h00; prev[s][n] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!out_valid && !oe0 && !oe1, "R1 reset", {out_valid, oe0, oe1}, 0);
        idle_cycle();
        // R9 IDLE ignores non-zero channel
        slot(7, 1'b1, -1, 1'b0, 1'b0);
        frame(1'b0, 2, 1'b0);   // fill, no load
        frame(1'b0, 2, 1'b1);   // R1: reset entries keep all outputs off
        frame(1'b1, 0, 1'b1);   // load map 0 (R4), still off (R7)
        frame(1'b1, 1, 1'b1);   // map 0 active, cross reversed (R3, R6); load map 1
        frame(1'b0, 2, 1'b1);   // map 1 active; junk ignored (R5)
        frame(1'b0, 2, 1'b1);   // map 1 still active (R5)
        // R9 slip mid-frame
        for (int n = 0; n < 10; n++) slot(n, 1'b0, 2, 1'b1, 1'b1);
        slot(12, 1'b1, -1, 1'b0, 1'b0);   // R4: untrusted control byte not written
        slot(13, 1'b1, -1, 1'b0, 1'b0);
        slot(5, 1'b1, -1, 1'b0, 1'b0);
        fr++;
        idle_cycle();
        frame(1'b0, 2, 1'b0);   // R9 refill, outputs off
        frame(1'b0, 2, 1'b1);   // map 1 intact, data from refill frame
        idle_cycle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule